// File: doc/BRIEF.md
# Dual-Trigger UART FIFO Controller

This block holds the transmit and receive byte queues of a UART and raises the interrupts that pace the CPU. The CPU pushes bytes into the transmit queue and the serial shifter drains it. The serial receiver pushes bytes into the receive queue and the CPU drains it. Each queue has its own 2-bit interrupt threshold. The transmit threshold is written alongside the receive one, but it only takes effect while an enhanced-mode bit is set. Until then the transmit interrupt behaves like a plain holding-register-empty flag.

A character-time tick from the baud logic drives a receive time-out. This time-out makes sure that a few bytes sitting below the receive threshold still reach the CPU. Serial shifting, baud generation and bus decode belong to neighbouring blocks.

Top module: `uart_dual_fifo_ctrl`

## Requirements
- R1: Each queue holds up to 16 entries in first-in first-out order; its count output reports 0 to 16, the full flag is high at 16 and the empty flag is high at 0.
- R2: When the stored enable bit is 0, pushes and pops are ignored, every interrupt output is low, and by the next clock edge both queues are empty and both overrun flags are clear; reset leaves the enable bit at 0 and all outputs at 0 except the empty flags.
- R3: The receive threshold code maps 00, 01, 10 and 11 to 1, 4, 8 and 14 characters; rx_trig_irq_o is high while the queues are enabled and the receive count is at or above that threshold.
- R4: tx_trig_irq_o is high while the queues are enabled and the transmit count is below the active transmit threshold, using the same code mapping as R3.
- R5: While the enhanced bit is 0, the active transmit threshold is 1 character, whatever code was written; a written transmit code is stored and applies as soon as the enhanced bit is 1.
- R6: rx_tout_irq_o goes high once 4 ticks have arrived with no receive push and no receive pop, while the receive queue is non-empty and its count is below the receive threshold.
- R7: Any receive push or receive pop clears rx_tout_irq_o at that edge and restarts the tick count.
- R8: A push into a full queue that is not popped in the same cycle is dropped and sets that queue's overrun flag, which stays set until the queues are disabled.
- R9: A pop from an empty queue leaves the data output and the count unchanged.
- R10: A push and a pop in the same cycle on a full queue both succeed: the count stays 16, the overrun flag is unchanged, and the head entry is delivered.
- R11: A successful pop loads the head entry into the queue's data output at that clock edge; the output holds until the next successful pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write strobe for enable and both threshold codes |
| ctrl_fifo_en_i | input | 1 | Queue enable value |
| ctrl_rx_lvl_i | input | 2 | Receive threshold code |
| ctrl_tx_lvl_i | input | 2 | Transmit threshold code |
| enh_we_i | input | 1 | Write strobe for the enhanced bit |
| enh_en_i | input | 1 | Enhanced bit value |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| tx_push_i | input | 1 | CPU writes a transmit byte |
| tx_data_i | input | 8 | Transmit byte in |
| tx_pop_i | input | 1 | Shifter takes a transmit byte |
| tx_data_o | output | 8 | Last transmit byte taken |
| rx_push_i | input | 1 | Receiver stores a byte |
| rx_data_i | input | 8 | Received byte in |
| rx_pop_i | input | 1 | CPU reads a received byte |
| rx_data_o | output | 8 | Last received byte read |
| tx_count_o | output | 5 | Transmit queue fill |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_ovr_o | output | 1 | Transmit overrun, sticky |
| rx_count_o | output | 5 | Receive queue fill |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_ovr_o | output | 1 | Receive overrun, sticky |
| rx_trig_irq_o | output | 1 | Receive threshold reached |
| tx_trig_irq_o | output | 1 | Transmit below threshold |
| rx_tout_irq_o | output | 1 | Receive time-out |

## Verification
Directed sequences first fill the receive queue to the brim and push once more. They then push and pop together on a full queue and pop an empty one. This separates a correctly dropped write from a wrapped pointer and a stale read from a moved pointer. A transmit pattern at fill 3 toggles the enhanced bit with code 11 stored, which shows whether the stored code is applied or masked. Tick runs of 3 and 4, broken by pushes and pops, pin the exact time-out point and its restart. Seeded random traffic with sparse reconfiguration then sweeps every threshold code against every fill, including simultaneous push and pop on both queues.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  function automatic logic [3:0] trig_chars(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 4'd1;
      TRIG_4:  return 4'd4;
      TRIG_8:  return 4'd8;
      default: return 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovr_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop_i & ~empty_o;
  // a pop in the same cycle frees the slot being written
  assign push_ok = push_i & (~full_o | pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_o    <= 1'b0;
      data_o   <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovr_o    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok) begin
        rd_ptr_q <= ptr_inc(rd_ptr_q);
        data_o   <= mem_q[rd_ptr_q];
      end
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
      if (push_i && !push_ok) ovr_o <= 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && !ovr_o)); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && ovr_o)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !flush_i) |=> $stable(data_o)); // R9
  AST_FULL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i && !flush_i) |=> (full_o && $stable(ovr_o))); // R10

endmodule

// File: rtl/uart_rx_tout.sv
module uart_rx_tout #(
  parameter int unsigned TOUT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic arm_i,
  input  logic below_i,
  output logic irq_o
);

  localparam int unsigned TW = $clog2(TOUT + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (tick_i && arm_i && cnt_q != TW'(TOUT)) cnt_q <= cnt_q + TW'(1);
  end

  assign irq_o = (cnt_q == TW'(TOUT)) & arm_i & below_i;

  AST_TOUT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o); // R7
  AST_TOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $stable(below_i)) |-> $past(tick_i)); // R6

endmodule

// File: rtl/uart_dual_fifo_ctrl.sv
module uart_dual_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH      = 16,
  parameter  int unsigned WIDTH      = 8,
  parameter  int unsigned TOUT_CHARS = 4,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_fifo_en_i,
  input  logic [1:0]       ctrl_rx_lvl_i,
  input  logic [1:0]       ctrl_tx_lvl_i,
  input  logic             enh_we_i,
  input  logic             enh_en_i,
  input  logic             char_tick_i,
  input  logic             tx_push_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_data_o,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic [CW-1:0]    tx_count_o,
  output logic             tx_full_o,
  output logic             tx_empty_o,
  output logic             tx_ovr_o,
  output logic [CW-1:0]    rx_count_o,
  output logic             rx_full_o,
  output logic             rx_empty_o,
  output logic             rx_ovr_o,
  output logic             rx_trig_irq_o,
  output logic             tx_trig_irq_o,
  output logic             rx_tout_irq_o
);

  localparam int unsigned NQ = 2; // 0: receive, 1: transmit

  logic       fifo_en_q, enh_q;
  logic [1:0] rx_lvl_q, tx_lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      rx_lvl_q  <= TRIG_1;
      tx_lvl_q  <= TRIG_1;
      enh_q     <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        fifo_en_q <= ctrl_fifo_en_i;
        rx_lvl_q  <= ctrl_rx_lvl_i;
        tx_lvl_q  <= ctrl_tx_lvl_i;
      end
      if (enh_we_i) enh_q <= enh_en_i;
    end
  end

  logic             q_push  [NQ];
  logic             q_pop   [NQ];
  logic [WIDTH-1:0] q_din   [NQ];
  logic [WIDTH-1:0] q_dout  [NQ];
  logic [CW-1:0]    q_cnt   [NQ];
  logic             q_full  [NQ];
  logic             q_empty [NQ];
  logic             q_ovr   [NQ];

  assign q_push[0] = rx_push_i & fifo_en_q;
  assign q_pop[0]  = rx_pop_i  & fifo_en_q;
  assign q_din[0]  = rx_data_i;
  assign q_push[1] = tx_push_i & fifo_en_q;
  assign q_pop[1]  = tx_pop_i  & fifo_en_q;
  assign q_din[1]  = tx_data_i;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    uart_fifo_buf #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .CW    (CW)
    ) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (~fifo_en_q),
      .push_i  (q_push[g]),
      .data_i  (q_din[g]),
      .pop_i   (q_pop[g]),
      .data_o  (q_dout[g]),
      .count_o (q_cnt[g]),
      .full_o  (q_full[g]),
      .empty_o (q_empty[g]),
      .ovr_o   (q_ovr[g])
    );
  end

  assign rx_data_o  = q_dout[0];
  assign rx_count_o = q_cnt[0];
  assign rx_full_o  = q_full[0];
  assign rx_empty_o = q_empty[0];
  assign rx_ovr_o   = q_ovr[0];
  assign tx_data_o  = q_dout[1];
  assign tx_count_o = q_cnt[1];
  assign tx_full_o  = q_full[1];
  assign tx_empty_o = q_empty[1];
  assign tx_ovr_o   = q_ovr[1];

  logic [CW-1:0] rx_thr, tx_thr;
  logic          tout_raw;

  assign rx_thr = CW'(trig_chars(rx_lvl_q));
  // stored transmit code is masked until enhanced mode is on
  assign tx_thr = enh_q ? CW'(trig_chars(tx_lvl_q)) : CW'(1);

  assign rx_trig_irq_o = fifo_en_q & (rx_count_o >= rx_thr);
  assign tx_trig_irq_o = fifo_en_q & (tx_count_o <  tx_thr);

  uart_rx_tout #(
    .TOUT (TOUT_CHARS)
  ) u_tout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~fifo_en_q | rx_push_i | rx_pop_i),
    .tick_i  (char_tick_i),
    .arm_i   (~rx_empty_o),
    .below_i (rx_count_o < rx_thr),
    .irq_o   (tout_raw)
  );

  assign rx_tout_irq_o = fifo_en_q & tout_raw;

  AST_TX_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_q && !enh_q) |-> (tx_trig_irq_o == tx_empty_o)); // R5
  AST_RX_TRIG14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_lvl_q == 2'b11 && rx_count_o < CW'(14)) |-> !rx_trig_irq_o); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_q |-> !(rx_trig_irq_o || tx_trig_irq_o || rx_tout_irq_o)); // R2

endmodule

// File: tb/uart_dual_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module uart_dual_fifo_ctrl_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       ctrl_we, ctrl_en, enh_we, enh_en, tick;
  logic [1:0] ctrl_rxl, ctrl_txl;
  logic       tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_din, rx_din, tx_dout, rx_dout;
  logic [4:0] tx_cnt, rx_cnt;
  logic       tx_full, tx_empty, tx_ovr, rx_full, rx_empty, rx_ovr;
  logic       rx_irq, tx_irq, tout_irq;

  uart_dual_fifo_ctrl u_uart_dual_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_fifo_en_i(ctrl_en),
    .ctrl_rx_lvl_i(ctrl_rxl), .ctrl_tx_lvl_i(ctrl_txl),
    .enh_we_i(enh_we), .enh_en_i(enh_en), .char_tick_i(tick),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .tx_count_o(tx_cnt), .tx_full_o(tx_full), .tx_empty_o(tx_empty), .tx_ovr_o(tx_ovr),
    .rx_count_o(rx_cnt), .rx_full_o(rx_full), .rx_empty_o(rx_empty), .rx_ovr_o(rx_ovr),
    .rx_trig_irq_o(rx_irq), .tx_trig_irq_o(tx_irq), .rx_tout_irq_o(tout_irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  byte unsigned rq[$];
  byte unsigned tq[$];
  int  m_rx_out, m_tx_out, m_tcnt;
  bit  m_rx_ovr, m_tx_ovr, m_en, m_enh;
  int  m_rxl, m_txl;

  function automatic int lvl(input int code);
    case (code & 3)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ctrl_we = 0; enh_we = 0; tick = 0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic model_edge();
    int  rs;
    bit  pop_ok, push_ok;
    rs = rq.size();
    if (!m_en)                      m_tcnt = 0;
    else if (rx_push || rx_pop)     m_tcnt = 0;
    else if (tick && rs > 0 && m_tcnt < 4) m_tcnt++;
    if (!m_en) begin
      rq.delete(); tq.delete();
      m_rx_ovr = 0; m_tx_ovr = 0;
    end else begin
      pop_ok  = rx_pop && rq.size() > 0;
      push_ok = rx_push && (rq.size() < 16 || pop_ok);
      if (pop_ok) m_rx_out = rq.pop_front();
      if (push_ok) rq.push_back(rx_din);
      if (rx_push && !push_ok) m_rx_ovr = 1;
      pop_ok  = tx_pop && tq.size() > 0;
      push_ok = tx_push && (tq.size() < 16 || pop_ok);
      if (pop_ok) m_tx_out = tq.pop_front();
      if (push_ok) tq.push_back(tx_din);
      if (tx_push && !push_ok) m_tx_ovr = 1;
    end
    if (ctrl_we) begin m_en = ctrl_en; m_rxl = ctrl_rxl; m_txl = ctrl_txl; end
    if (enh_we) m_enh = enh_en;
  endtask

  task automatic compare_all();
    int rs, ts, thr;
    rs = rq.size(); ts = tq.size();
    thr = m_enh ? lvl(m_txl) : 1;
    chk("R1", "rx_count", rx_cnt, rs);
    chk("R1", "tx_count", tx_cnt, ts);
    chk("R1", "rx_full",  rx_full,  rs == 16);
    chk("R1", "rx_empty", rx_empty, rs == 0);
    chk("R1", "tx_full",  tx_full,  ts == 16);
    chk("R1", "tx_empty", tx_empty, ts == 0);
    chk("R11", "rx_data", rx_dout, m_rx_out);
    chk("R11", "tx_data", tx_dout, m_tx_out);
    chk("R8", "rx_ovr", rx_ovr, m_rx_ovr);
    chk("R8", "tx_ovr", tx_ovr, m_tx_ovr);
    chk("R3", "rx_trig", rx_irq, m_en && rs >= lvl(m_rxl));
    chk("R4", "tx_trig", tx_irq, m_en && ts < thr);
    chk("R6", "rx_tout", tout_irq, m_en && m_tcnt == 4 && rs > 0 && rs < lvl(m_rxl));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic cfg(input bit en, input int rxl, input int txl);
    ctrl_we = 1; ctrl_en = en; ctrl_rxl = 2'(rxl); ctrl_txl = 2'(txl);
    step();
  endtask

  task automatic put_rx(input int d);
    rx_push = 1; rx_din = 8'(d); step();
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; step(); end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; idle(); ctrl_en = 0; ctrl_rxl = 0; ctrl_txl = 0; enh_en = 0;
    tx_din = 0; rx_din = 0;
    m_rx_out = 0; m_tx_out = 0; m_tcnt = 0; m_rx_ovr = 0; m_tx_ovr = 0;
    m_en = 0; m_enh = 0; m_rxl = 0; m_txl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    chk("R2", "reset rx_empty", rx_empty, 1);
    chk("R2", "reset tx_trig", tx_irq, 0);

    // pushes while disabled are ignored
    rx_push = 1; tx_push = 1; rx_din = 8'h3C; tx_din = 8'h3D; step();
    chk("R2", "disabled rx_count", rx_cnt, 0);

    cfg(1, 1, 3); // rx level 4, tx code 14 stored
    chk("R5", "tx_trig empty default", tx_irq, 1);
    for (int i = 0; i < 3; i++) begin tx_push = 1; tx_din = 8'(8'hA0 + i); step(); end
    chk("R5", "tx_trig fill3 default", tx_irq, 0);
    enh_we = 1; enh_en = 1; step();
    chk("R5", "tx_trig fill3 enhanced", tx_irq, 1);
    enh_we = 1; enh_en = 0; step();
    chk("R5", "tx_trig fill3 masked", tx_irq, 0);
    tx_pop = 1; step();
    chk("R11", "tx head", tx_dout, 8'hA0);

    for (int i = 0; i < 16; i++) put_rx(8'h10 + i);
    chk("R1", "rx full", rx_full, 1);
    chk("R3", "rx_trig at 16", rx_irq, 1);
    put_rx(8'hEE);
    chk("R8", "rx_ovr", rx_ovr, 1);
    chk("R8", "rx_count after drop", rx_cnt, 16);
    rx_push = 1; rx_pop = 1; rx_din = 8'h55; step();
    chk("R10", "count push+pop full", rx_cnt, 16);
    chk("R10", "head push+pop full", rx_dout, 8'h10);
    for (int i = 0; i < 16; i++) begin rx_pop = 1; step(); end
    chk("R1", "fifo order tail", rx_dout, 8'h55);
    rx_pop = 1; step();
    chk("R9", "pop empty data", rx_dout, 8'h55);
    chk("R9", "pop empty count", rx_cnt, 0);

    put_rx(8'h77);
    do_ticks(3);
    chk("R6", "tout after 3", tout_irq, 0);
    do_ticks(1);
    chk("R6", "tout after 4", tout_irq, 1);
    put_rx(8'h78);
    chk("R7", "tout cleared by push", tout_irq, 0);
    do_ticks(4);
    chk("R6", "tout again", tout_irq, 1);
    rx_pop = 1; step();
    chk("R7", "tout cleared by pop", tout_irq, 0);
    chk("R11", "rx head", rx_dout, 8'h77);

    cfg(0, 1, 3);
    step();
    chk("R2", "flush rx_count", rx_cnt, 0);
    chk("R2", "flush rx_ovr", rx_ovr, 0);

    cfg(1, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 255));
      if (r < 4) begin
        ctrl_we = 1; ctrl_en = ($urandom_range(0, 7) != 0);
        ctrl_rxl = 2'($urandom_range(0, 3)); ctrl_txl = 2'($urandom_range(0, 3));
      end else if (r < 8) begin
        enh_we = 1; enh_en = 1'($urandom_range(0, 1));
      end
      rx_push = ($urandom_range(0, 9) < 5); rx_din = 8'($urandom);
      rx_pop  = ($urandom_range(0, 9) < 4);
      tx_push = ($urandom_range(0, 9) < 5); tx_din = 8'($urandom);
      tx_pop  = ($urandom_range(0, 9) < 4);
      if ($urandom_range(0, 3) == 0) begin rx_push = 0; rx_pop = 0; end
      tick = ($urandom_range(0, 3) == 0);
      step();
    end
    finish_run();
  end

endmodule